// File: doc/BRIEF.md
# Clock Source Stop Control with Stabilization Status

This block keeps the run/stop state of three clock sources: the main oscillator (crystal or external clock), the sub oscillator (crystal or external clock), and the internal high-speed oscillator. Software writes a stop byte to request that sources halt. Each request to halt a source is checked against a configuration byte that records which source drives the CPU. A request that would halt the active CPU source is refused. The old stop value is kept, and a sticky error flag is set.

The block also has an oscillation-stabilization counter for the main oscillator. A counting run starts in two cases: when the main oscillator is released from stop in crystal mode, or when a wake pulse ends low-power STOP mode. A STOP-entry pulse, an accepted main-stop write, or reset clears the counter. Progress shows as an 8-bit status byte that fills from the MSB downward as eight thresholds are passed, and it can be read as a whole byte or one bit at a time.

The stop-mode request and wake inputs are single-cycle pulses that stand in for the power controller.

Top module: `osc_stop_ctrl`

## Requirements
- R1: After a synchronous reset: stop byte main=1, sub=1, internal=0; configuration byte 00h; error flag 0; status 00h; read outputs 0.
- R2: Stop byte bit 7 (main) may go from 0 to 1 only if configuration bit 1 (sub select) is 1 or configuration bit 0 (main select) is 0.
- R3: Stop byte bit 6 (sub) may go from 0 to 1 only if configuration bit 1 is 0.
- R4: Stop byte bit 0 (internal) may go from 0 to 1 only if configuration bit 1 is 1 or configuration bit 0 is 1.
- R5: A refused bit keeps its old value and sets the error flag. The flag stays set until reset. Writing 0 to a stop bit is always accepted, and accepted bits of the same write still update.
- R6: The status byte is cleared to 00h one cycle after a stop_req pulse, and one cycle after an accepted stop write with bit 7 set.
- R7: A counting run starts when a stop write clears bit 7 while it was 1, with configuration bit 4 (external clock) = 0 and bit 5 (oscillator select) = 1. No run starts otherwise. A clear on the same cycle wins over a start.
- R8: A wake pulse starts (or restarts) a counting run.
- R9: If the run started at edge E, then after edge E+n the status holds bit 7-k set for each k in 0..7 with n-1 >= 2^(FIRST_EXP+k). The status saturates at FFh.
- R10: rd_data takes, one edge later, the byte at rd_addr: 0 = stop byte {main,sub,00000,internal}, 1 = configuration byte, 2 = status, 3 = {0000000,error}. rd_bit takes status[rd_bit_sel] one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 stop, 1 configuration) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_bit_sel | input | 3 | Status bit index for single-bit read |
| stop_req | input | 1 | STOP-mode entry pulse |
| wake | input | 1 | STOP-mode release pulse |
| rd_data | output | 8 | Registered byte read |
| rd_bit | output | 1 | Registered single status bit |
| stop_o | output | 3 | Stop bits {main,sub,internal} |
| err_o | output | 1 | Sticky refused-stop flag |

## Verification
Stop writes are tried under each of the three CPU-source selections, so the bench can tell a correctly refused stop from a wrong refusal of a permitted one. Mixed writes, where one bit is refused and the others are accepted, show that each bit is decided on its own. Counter starts are driven by a crystal-mode release, by an external-mode release (which must not start a run) and by wake. Clears come from stop_req and from a main-stop write during a run, which shows clear priority and a restart from zero. The threshold fill is followed to saturation with reads by byte and by bit.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  localparam int ADDR_W   = 2;
  localparam int IDX_HIO  = 0;
  localparam int IDX_SUB  = 1;
  localparam int IDX_MAIN = 2;
  localparam logic [ADDR_W-1:0] A_STOP = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_ERR  = 2'd3;
  localparam int CFG_MSEL = 0;
  localparam int CFG_SSEL = 1;
  localparam int CFG_EXT  = 4;
  localparam int CFG_OSC  = 5;
endpackage

// File: rtl/osc_stop_guard.sv
module osc_stop_guard
  import ocs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [2:0] req,
  input  logic       main_sel,
  input  logic       sub_sel,
  input  logic       ext_clk,
  input  logic       osc_sel,
  output logic [2:0] stop_q,
  output logic       err_q,
  output logic       stab_clr,
  output logic       stab_start
);
  logic [2:0] ok, reject, nxt;

  always_comb begin
    ok[IDX_MAIN] = sub_sel | ~main_sel;
    ok[IDX_SUB]  = ~sub_sel;
    ok[IDX_HIO]  = sub_sel | main_sel;
  end

  for (genvar i = 0; i < 3; i++) begin : g_bit
    assign reject[i] = wr & req[i] & ~stop_q[i] & ~ok[i];
    assign nxt[i]    = (wr & ~reject[i]) ? req[i] : stop_q[i];
  end

  assign stab_clr   = wr & req[IDX_MAIN] & ~reject[IDX_MAIN];
  assign stab_start = wr & ~req[IDX_MAIN] & stop_q[IDX_MAIN] & ~ext_clk & osc_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 3'b110;
      err_q  <= 1'b0;
    end else begin
      stop_q <= nxt;
      if (|reject) err_q <= 1'b1;
    end
  end

  // R2
  main_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_q[IDX_MAIN] && main_sel && !sub_sel) |=> !stop_q[IDX_MAIN]);
  // R3
  sub_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_q[IDX_SUB] && sub_sel) |=> !stop_q[IDX_SUB]);
  // R4
  hio_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop_q[IDX_HIO] && !sub_sel && !main_sel) |=> !stop_q[IDX_HIO]);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int FIRST_EXP = 8,
  parameter int NSTEP     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  output logic [NSTEP-1:0] stat
);
  localparam int CNT_W = FIRST_EXP + NSTEP;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1) << (FIRST_EXP + NSTEP - 1);

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [NSTEP-1:0] therm;

  for (genvar k = 0; k < NSTEP; k++) begin : g_thr
    assign therm[NSTEP-1-k] = (cnt >= (CNT_W'(1) << (FIRST_EXP + k)));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      run  <= 1'b0;
      stat <= '0;
    end else if (start) begin
      cnt  <= '0;
      run  <= 1'b1;
      stat <= '0;
    end else begin
      stat <= therm;
      if (run && cnt != LAST) cnt <= cnt + 1'b1;
    end
  end

  // R9
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    stat == NSTEP'(~({NSTEP{1'b1}} >> $countones(stat))));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> stat == '0);
  // R9
  grow_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !start) |=> $countones(stat) >= $countones($past(stat)));
endmodule

// File: rtl/osc_stop_ctrl.sv
module osc_stop_ctrl
  import ocs_pkg::*;
#(
  parameter int FIRST_EXP = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  input  logic [2:0]  rd_bit_sel,
  input  logic        stop_req,
  input  logic        wake,
  output logic [7:0]  rd_data,
  output logic        rd_bit,
  output logic [2:0]  stop_o,
  output logic        err_o
);
  logic [7:0] cfg_q;
  logic [7:0] stat;
  logic       g_clr, g_start;
  logic       wr_stop;

  assign wr_stop = wr_en && (wr_addr == A_STOP);

  always_ff @(posedge clk) begin
    if (rst)                              cfg_q <= '0;
    else if (wr_en && wr_addr == A_CFG)   cfg_q <= wr_data;
  end

  osc_stop_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_stop),
    .req       ({wr_data[7], wr_data[6], wr_data[0]}),
    .main_sel  (cfg_q[CFG_MSEL]),
    .sub_sel   (cfg_q[CFG_SSEL]),
    .ext_clk   (cfg_q[CFG_EXT]),
    .osc_sel   (cfg_q[CFG_OSC]),
    .stop_q    (stop_o),
    .err_q     (err_o),
    .stab_clr  (g_clr),
    .stab_start(g_start)
  );

  stab_counter #(.FIRST_EXP(FIRST_EXP), .NSTEP(8)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (g_clr | stop_req),
    .start(g_start | wake),
    .stat (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_bit  <= 1'b0;
    end else begin
      rd_bit <= stat[rd_bit_sel];
      case (rd_addr)
        A_STOP:  rd_data <= {stop_o[IDX_MAIN], stop_o[IDX_SUB], 5'b0, stop_o[IDX_HIO]};
        A_CFG:   rd_data <= cfg_q;
        A_STAT:  rd_data <= stat;
        default: rd_data <= {7'b0, err_o};
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stop_o == 3'b110 && !err_o && rd_data == 8'h00));
  // R10
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_STAT) |=> rd_data == $past(stat));
endmodule

// File: tb/tb_osc_stop_ctrl.sv
module tb_osc_stop_ctrl;
  localparam int FE = 2;
  logic clk = 0, rst = 1, wr_en = 0, stop_req = 0, wake = 0;
  logic [1:0] wr_addr = 0, rd_addr = 2;
  logic [7:0] wr_data = 0;
  logic [2:0] rd_bit_sel = 0;
  logic [7:0] rd_data;
  logic rd_bit, err_o;
  logic [2:0] stop_o;

  always #5 clk = ~clk;

  osc_stop_ctrl #(.FIRST_EXP(FE)) dut (.*);

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";
  logic started = 0;

  // behavioural reference
  logic m_main, m_sub, m_hio, m_err, m_run, e_bit;
  logic [7:0] m_cfg, m_stat, e_rd;
  int m_cnt;

  function automatic logic [7:0] therm(int c);
    logic [7:0] t = 0;
    for (int k = 0; k < 8; k++) if (c >= (1 << (FE + k))) t[7-k] = 1;
    return t;
  endfunction

  always @(posedge clk) begin
    logic clr, st, okm, oks, okh, sel_m, sel_s;
    cyc++;
    started <= 1;
    if (rst) begin
      m_main = 1; m_sub = 1; m_hio = 0; m_err = 0; m_cfg = 0;
      m_stat = 0; m_cnt = 0; m_run = 0; e_rd = 0; e_bit = 0;
    end else begin
      e_bit = m_stat[rd_bit_sel];
      case (rd_addr)
        0: e_rd = {m_main, m_sub, 5'b0, m_hio};
        1: e_rd = m_cfg;
        2: e_rd = m_stat;
        default: e_rd = {7'b0, m_err};
      endcase
      sel_m = m_cfg[0]; sel_s = m_cfg[1];
      clr = stop_req; st = wake;
      if (wr_en && wr_addr == 1) m_cfg = wr_data;
      if (wr_en && wr_addr == 0) begin
        okm = sel_s || !sel_m; oks = !sel_s; okh = sel_s || sel_m;
        if (!wr_data[7] && m_main && !m_cfg[4] && m_cfg[5]) st = 1;
        if (wr_data[7] && !m_main && !okm) m_err = 1;
        else begin m_main = wr_data[7]; if (wr_data[7]) clr = 1; end
        if (wr_data[6] && !m_sub && !oks) m_err = 1; else m_sub = wr_data[6];
        if (wr_data[0] && !m_hio && !okh) m_err = 1; else m_hio = wr_data[0];
      end
      if (clr) begin m_cnt = 0; m_run = 0; m_stat = 0; end
      else if (st) begin m_cnt = 0; m_run = 1; m_stat = 0; end
      else begin
        m_stat = therm(m_cnt);
        if (m_run && m_cnt < (1 << (FE + 7))) m_cnt++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (started && !rst) begin
    chk(phase, {23'b0, stop_o, err_o, rd_bit, rd_data[3:0]},
        {23'b0, m_main, m_sub, m_hio, m_err, e_bit, e_rd[3:0]});
    chk(phase, {24'b0, rd_data}, {24'b0, e_rd});
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_reset;
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
  endtask
  task automatic pulse_stop;
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
  endtask
  task automatic pulse_wake;
    @(negedge clk); wake = 1; @(negedge clk); wake = 0;
  endtask

  initial begin
    idle(3); rst = 0;
    idle(2);
    chk("R1", {29'b0, stop_o, err_o}, {29'b0, 3'b110, 1'b0});
    chk("R1", rd_data, 0);
    // R7 negative: oscillator select 0, release main
    phase = "R7"; wr(1, 8'h00); wr(0, 8'h40); idle(20);
    chk("R7", rd_data, 0);
    // R2: CPU on main -> main stop refused
    phase = "R2"; wr(1, 8'h01); wr(0, 8'hC0); idle(2);
    chk("R2", {30'b0, stop_o[2], err_o}, {30'b0, 1'b0, 1'b1});
    wr(1, 8'h02); wr(0, 8'hC0); idle(2);
    chk("R2", stop_o[2], 1);
    // R3
    phase = "R3"; do_reset; wr(0, 8'h00); wr(1, 8'h02); wr(0, 8'h40); idle(2);
    chk("R3", {30'b0, stop_o[1], err_o}, {30'b0, 1'b0, 1'b1});
    do_reset; wr(0, 8'h00); wr(0, 8'h40); idle(2);
    chk("R3", {30'b0, stop_o[1], err_o}, {30'b0, 1'b1, 1'b0});
    // R4 and R5 mixed write
    phase = "R4"; do_reset; wr(0, 8'h41); idle(2);
    chk("R5", {29'b0, stop_o, err_o}, {29'b0, 3'b010, 1'b1});
    wr(1, 8'h01); wr(0, 8'h01); idle(2);
    chk("R4", stop_o[0], 1);
    phase = "R5"; wr(0, 8'h00); idle(3);
    chk("R5", {29'b0, stop_o, err_o}, {29'b0, 3'b000, 1'b1});
    // R9 fill from crystal-mode release
    phase = "R9"; do_reset; wr(1, 8'h20); rd_addr = 2; wr(0, 8'h40);
    idle(600);
    chk("R9", rd_data, 8'hFF);
    phase = "R10";
    for (int b = 0; b < 8; b++) begin
      rd_bit_sel = 3'(b); idle(2); chk("R10", rd_bit, 1);
    end
    // R6 stop entry clears
    phase = "R6"; pulse_stop; idle(1);
    chk("R6", rd_data, 0);
    // R8 wake
    phase = "R8"; pulse_wake; idle(40);
    chk("R8", rd_data, therm(38));
    // R6 main stop write during run; R7 external mode no start
    phase = "R6"; wr(0, 8'hC0); idle(1);
    chk("R6", rd_data, 0);
    phase = "R7"; wr(1, 8'h30); wr(0, 8'h40); idle(30);
    chk("R7", rd_data, 0);
    wr(0, 8'hC0); wr(1, 8'h20); wr(0, 8'h40); idle(30);
    chk("R7", rd_data, therm(28));
    // R10 other addresses
    phase = "R10";
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); idle(3);
    end
    rd_addr = 1; idle(2); chk("R10", rd_data, 8'h20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule